// File: doc/BRIEF.md
# Three-Field Microcoded Accumulator Datapath

This block is the register and arithmetic side of a small microprogrammed processor. It holds a 16-bit accumulator (AC), a 16-bit data register (DR), an 11-bit address register (AR) and an 11-bit program counter (PC). A sequencer outside the block supplies three 3-bit microoperation fields every clock. Each field is decoded on its own, and all the transfers the fields name are committed together on the next rising edge. Every transfer reads the register values from before that edge, so one microinstruction can exchange two registers.

The block drives a single-port synchronous memory. It supplies an address, write data and a write strobe, and it receives read data one cycle later. It returns three condition bits to the sequencer for branching: the top bit of DR, which is the indirect flag of an instruction word whose bit 15 is indirect, bits 14..11 are the opcode and bits 10..0 are the address; the sign of AC; and an AC-is-zero flag.

Top module: `micro_datapath`

## Requirements
- R1: While rst_n is low, AC, DR, AR and PC are cleared to zero, and they read zero after release.
- R2: Field one acts as follows. 0 does nothing. 1 sets AC=AC+DR. 2 clears AC. 3 sets AC=AC+1. 4 copies DR into AC. 5 loads AR from DR bits 10..0. 6 loads AR from PC. 7 writes DR to memory.
- R3: Field two acts as follows. 0 does nothing. 1 sets AC=AC-DR. 2 sets AC=AC OR DR. 3 sets AC=AC AND DR. 4 loads DR from mem_rdata. 5 copies AC into DR. 6 sets DR=DR+1. 7 loads PC into DR bits 10..0 and keeps DR bits 15..11.
- R4: Field three acts as follows. 0 and 7 do nothing. 1 sets AC=AC XOR DR. 2 inverts every bit of AC. 3 shifts AC left one place. 4 shifts AC right one place. Both shifts are logical and fill with 0. 5 sets PC=PC+1. 6 loads PC from AR.
- R5: AR changes only when field one is 5 or 6.
- R6: When several fields write AC in one cycle, field one wins over field two, and field two wins over field three.
- R7: Every transfer samples its sources from before the edge. Field one 4 together with field two 5 exchanges AC and DR.
- R8: mem_we is high exactly when field one is 7, and mem_wdata is DR. mem_addr shows the value AR holds after the coming edge. Read data arrives in the cycle after that address is shown, and a field-two 4 in that cycle loads it into DR.
- R9: cond_ind is DR bit 15, cond_sign is AC bit 15, and cond_zero is high when AC is zero.
- R10: Addition, subtraction and increments wrap modulo 2^16 (PC modulo 2^11), and no carry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| f1_op | input | 3 | Microoperation field one |
| f2_op | input | 3 | Microoperation field two |
| f3_op | input | 3 | Microoperation field three |
| mem_rdata | input | 16 | Read data, one cycle after the address |
| mem_addr | output | 11 | Memory address (AR after the coming edge) |
| mem_wdata | output | 16 | Write data (DR) |
| mem_we | output | 1 | Memory write strobe |
| ac_q | output | 16 | Accumulator |
| dr_q | output | 16 | Data register |
| ar_q | output | 11 | Address register |
| pc_q | output | 11 | Program counter |
| cond_ind | output | 1 | DR bit 15 |
| cond_sign | output | 1 | AC bit 15 |
| cond_zero | output | 1 | AC equals zero |

## Verification
The hardest cases to reach are the collisions: one microinstruction whose fields all write AC, or that exchanges AC and DR, while both registers hold distinct, nonzero values. To reach them, the stimulus first builds known register contents through ordinary microoperations. It then walks all 512 field combinations in several scrambled orders, starting each walk from the state the previous step left. A bench memory model supplies the read side, so write-then-read round trips through AR happen naturally along the way.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 11;
  localparam int FLD_W  = 3;

  typedef enum logic [FLD_W-1:0] {
    A_NOP, A_ADD, A_CLR, A_INC, A_FROM_DR, A_AR_DR, A_AR_PC, A_WRITE
  } fld1_e;

  typedef enum logic [FLD_W-1:0] {
    B_NOP, B_SUB, B_OR, B_AND, B_READ, B_DR_AC, B_DR_INC, B_DR_PC
  } fld2_e;

  typedef enum logic [FLD_W-1:0] {
    C_NOP, C_XOR, C_NOT, C_SHL, C_SHR, C_PC_INC, C_PC_AR, C_RSVD
  } fld3_e;

  typedef struct packed {
    logic dr_from_mem;
    logic dr_from_ac;
    logic dr_incr;
    logic dr_low_pc;
    logic ar_from_dr;
    logic ar_from_pc;
    logic pc_incr;
    logic pc_from_ar;
    logic mem_wr;
  } ctl_t;
endpackage

// File: rtl/mdp_field_dec.sv
module mdp_field_dec
  import mdp_pkg::*;
(
  input  fld1_e f1_i,
  input  fld2_e f2_i,
  input  fld3_e f3_i,
  output ctl_t  ctl_o
);
  always_comb begin
    ctl_o             = '0;
    ctl_o.ar_from_dr  = (f1_i == A_AR_DR);
    ctl_o.ar_from_pc  = (f1_i == A_AR_PC);
    ctl_o.mem_wr      = (f1_i == A_WRITE);
    ctl_o.dr_from_mem = (f2_i == B_READ);
    ctl_o.dr_from_ac  = (f2_i == B_DR_AC);
    ctl_o.dr_incr     = (f2_i == B_DR_INC);
    ctl_o.dr_low_pc   = (f2_i == B_DR_PC);
    ctl_o.pc_incr     = (f3_i == C_PC_INC);
    ctl_o.pc_from_ar  = (f3_i == C_PC_AR);
  end
endmodule

// File: rtl/mdp_acc_next.sv
module mdp_acc_next
  import mdp_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  fld1_e         f1_i,
  input  fld2_e         f2_i,
  input  fld3_e         f3_i,
  input  logic [DW-1:0] ac_i,
  input  logic [DW-1:0] dr_i,
  output logic [DW-1:0] ac_nxt_o,
  output logic          ac_we_o,
  output logic [1:0]    ac_src_o
);
  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] wrap_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DW-1:0] lsl1(input logic [DW-1:0] a);
    return {a[DW-2:0], 1'b0};
  endfunction

  function automatic logic [DW-1:0] lsr1(input logic [DW-1:0] a);
    return {1'b0, a[DW-1:1]};
  endfunction

  logic          hit1, hit2, hit3;
  logic [DW-1:0] val1, val2, val3;

  always_comb begin
    hit1 = 1'b1;
    val1 = ac_i;
    unique case (f1_i)
      A_ADD:     val1 = wrap_add(ac_i, dr_i);
      A_CLR:     val1 = '0;
      A_INC:     val1 = wrap_add(ac_i, {{(DW-1){1'b0}}, 1'b1});
      A_FROM_DR: val1 = dr_i;
      default:   hit1 = 1'b0;
    endcase
  end

  always_comb begin
    hit2 = 1'b1;
    val2 = ac_i;
    unique case (f2_i)
      B_SUB:   val2 = wrap_sub(ac_i, dr_i);
      B_OR:    val2 = ac_i | dr_i;
      B_AND:   val2 = ac_i & dr_i;
      default: hit2 = 1'b0;
    endcase
  end

  always_comb begin
    hit3 = 1'b1;
    val3 = ac_i;
    unique case (f3_i)
      C_XOR:   val3 = ac_i ^ dr_i;
      C_NOT:   val3 = ~ac_i;
      C_SHL:   val3 = lsl1(ac_i);
      C_SHR:   val3 = lsr1(ac_i);
      default: hit3 = 1'b0;
    endcase
  end

  // fixed priority: field one, then two, then three
  always_comb begin
    ac_we_o  = hit1 | hit2 | hit3;
    ac_src_o = 2'd0;
    ac_nxt_o = ac_i;
    if (hit1) begin
      ac_src_o = 2'd1;
      ac_nxt_o = val1;
    end else if (hit2) begin
      ac_src_o = 2'd2;
      ac_nxt_o = val2;
    end else if (hit3) begin
      ac_src_o = 2'd3;
      ac_nxt_o = val3;
    end
  end
endmodule

// File: rtl/micro_datapath.sv
module micro_datapath
  import mdp_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    f1_op,
  input  logic [2:0]    f2_op,
  input  logic [2:0]    f3_op,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [DW-1:0] ac_q,
  output logic [DW-1:0] dr_q,
  output logic [AW-1:0] ar_q,
  output logic [AW-1:0] pc_q,
  output logic          cond_ind,
  output logic          cond_sign,
  output logic          cond_zero
);
  localparam int HI_W = DW - AW;

  fld1_e f1;
  fld2_e f2;
  fld3_e f3;
  assign f1 = fld1_e'(f1_op);
  assign f2 = fld2_e'(f2_op);
  assign f3 = fld3_e'(f3_op);

  logic [DW-1:0] ac_r, dr_r, ac_nxt, dr_nxt;
  logic [AW-1:0] ar_r, pc_r, ar_nxt, pc_nxt;
  logic          ac_we;
  logic [1:0]    ac_src;
  ctl_t          ctl;

  mdp_field_dec u_dec (
    .f1_i  (f1),
    .f2_i  (f2),
    .f3_i  (f3),
    .ctl_o (ctl)
  );

  mdp_acc_next #(.DW(DW)) u_acc (
    .f1_i     (f1),
    .f2_i     (f2),
    .f3_i     (f3),
    .ac_i     (ac_r),
    .dr_i     (dr_r),
    .ac_nxt_o (ac_nxt),
    .ac_we_o  (ac_we),
    .ac_src_o (ac_src)
  );

  always_comb begin
    dr_nxt = dr_r;
    if (ctl.dr_from_mem)     dr_nxt = mem_rdata;
    else if (ctl.dr_from_ac) dr_nxt = ac_r;
    else if (ctl.dr_incr)    dr_nxt = dr_r + {{(DW-1){1'b0}}, 1'b1};
    else if (ctl.dr_low_pc)  dr_nxt = {dr_r[DW-1 -: HI_W], pc_r};
  end

  always_comb begin
    ar_nxt = ar_r;
    if (ctl.ar_from_dr)      ar_nxt = dr_r[AW-1:0];
    else if (ctl.ar_from_pc) ar_nxt = pc_r;
  end

  always_comb begin
    pc_nxt = pc_r;
    if (ctl.pc_incr)         pc_nxt = pc_r + {{(AW-1){1'b0}}, 1'b1};
    else if (ctl.pc_from_ar) pc_nxt = ar_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_r <= '0;
      dr_r <= '0;
      ar_r <= '0;
      pc_r <= '0;
    end else begin
      if (ac_we) ac_r <= ac_nxt;
      dr_r <= dr_nxt;
      ar_r <= ar_nxt;
      pc_r <= pc_nxt;
    end
  end

  assign mem_addr  = ar_nxt;
  assign mem_wdata = dr_r;
  assign mem_we    = ctl.mem_wr;
  assign ac_q      = ac_r;
  assign dr_q      = dr_r;
  assign ar_q      = ar_r;
  assign pc_q      = pc_r;
  assign cond_ind  = dr_r[DW-1];
  assign cond_sign = ac_r[DW-1];
  assign cond_zero = (ac_r == '0);

  a_r7_swap_ac_dr: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == A_FROM_DR && f2 == B_DR_AC) |=> (ac_r == $past(dr_r) && dr_r == $past(ac_r)));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == A_CLR) |=> (ac_r == '0));

  a_r6_src_matches_field1: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == A_ADD || f1 == A_INC) |-> (ac_src == 2'd1));

  a_r8_write_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == ar_r));

  a_r5_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(f1 == A_AR_DR || f1 == A_AR_PC) |=> $stable(ar_r));

  a_r4_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(f3 == C_PC_INC || f3 == C_PC_AR) |=> $stable(pc_r));

  a_r3_dr_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (f2 == B_DR_PC) |=> (dr_r[DW-1 -: HI_W] == $past(dr_r[DW-1 -: HI_W])));

  a_r10_inc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == A_INC && ac_r == '1) |=> (ac_r == '0));
endmodule

// File: tb/test_micro_datapath.sv
`timescale 1ns/1ps
module test_micro_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  f1_op = 3'd0, f2_op = 3'd0, f3_op = 3'd0;
  logic [15:0] mem_rdata;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] ac_q, dr_q;
  logic [10:0] ar_q, pc_q;
  logic        cond_ind, cond_sign, cond_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  micro_datapath i_micro_datapath (
    .clk(clk), .rst_n(rst_n), .f1_op(f1_op), .f2_op(f2_op), .f3_op(f3_op),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .ac_q(ac_q), .dr_q(dr_q), .ar_q(ar_q), .pc_q(pc_q),
    .cond_ind(cond_ind), .cond_sign(cond_sign), .cond_zero(cond_zero)
  );

  // synchronous single-port memory, read data one cycle after the address
  logic [15:0] mem [0:2047];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  logic [15:0] m_ac = 16'h0, m_dr = 16'h0;
  logic [10:0] m_ar = 11'h0, m_pc = 11'h0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called right after a falling edge
  task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c, input string tag);
    logic [15:0] n_ac, n_dr;
    logic [10:0] n_ar, n_pc;
    f1_op = a; f2_op = b; f3_op = c;
    #1;
    n_ac = m_ac;
    if (a >= 3'd1 && a <= 3'd4) begin
      if (a == 3'd1) n_ac = m_ac + m_dr;
      if (a == 3'd2) n_ac = 16'h0;
      if (a == 3'd3) n_ac = m_ac + 16'h1;
      if (a == 3'd4) n_ac = m_dr;
    end else if (b >= 3'd1 && b <= 3'd3) begin
      if (b == 3'd1) n_ac = m_ac - m_dr;
      if (b == 3'd2) n_ac = m_ac | m_dr;
      if (b == 3'd3) n_ac = m_ac & m_dr;
    end else begin
      if (c == 3'd1) n_ac = m_ac ^ m_dr;
      if (c == 3'd2) n_ac = ~m_ac;
      if (c == 3'd3) n_ac = m_ac << 1;
      if (c == 3'd4) n_ac = m_ac >> 1;
    end
    n_dr = m_dr;
    if (b == 3'd4) n_dr = mem_rdata;
    if (b == 3'd5) n_dr = m_ac;
    if (b == 3'd6) n_dr = m_dr + 16'h1;
    if (b == 3'd7) n_dr = {m_dr[15:11], m_pc};
    n_ar = (a == 3'd5) ? m_dr[10:0] : (a == 3'd6) ? m_pc : m_ar;
    n_pc = (c == 3'd5) ? m_pc + 11'h1 : (c == 3'd6) ? m_ar : m_pc;
    chk({"R8 we ", tag}, {31'h0, mem_we}, {31'h0, (a == 3'd7)});
    chk({"R8 addr ", tag}, {21'h0, mem_addr}, {21'h0, n_ar});
    if (a == 3'd7) chk({"R8 wdata ", tag}, {16'h0, mem_wdata}, {16'h0, m_dr});
    @(posedge clk);
    @(negedge clk);
    m_ac = n_ac; m_dr = n_dr; m_ar = n_ar; m_pc = n_pc;
    chk({"AC ", tag}, {16'h0, ac_q}, {16'h0, m_ac});
    chk({"DR ", tag}, {16'h0, dr_q}, {16'h0, m_dr});
    chk({"AR ", tag}, {21'h0, ar_q}, {21'h0, m_ar});
    chk({"PC ", tag}, {21'h0, pc_q}, {21'h0, m_pc});
    chk({"R9 flags ", tag}, {29'h0, cond_ind, cond_sign, cond_zero},
        {29'h0, m_dr[15], m_ac[15], (m_ac == 16'h0)});
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'(i * 40503 + 4660);
    repeat (3) @(negedge clk);
    chk("R1 reset regs", {ac_q, dr_q}, 32'h0);
    chk("R1 reset addr", {ar_q, pc_q}, 32'h0);
    chk("R9 reset zero flag", {31'h0, cond_zero}, 32'h1);
    rst_n = 1'b1;

    step(3'd2, 3'd0, 3'd2, "R2 clear then R4 invert loses");
    chk("R6 clear beats invert", {16'h0, ac_q}, 32'h0);
    step(3'd0, 3'd0, 3'd2, "R4 invert");
    chk("R4 invert", {16'h0, ac_q}, 32'hFFFF);
    step(3'd3, 3'd0, 3'd0, "R10 increment wrap");
    chk("R10 inc wraps", {31'h0, cond_zero}, 32'h1);
    step(3'd0, 3'd0, 3'd2, "R4 invert");
    step(3'd0, 3'd0, 3'd4, "R4 shift right");
    chk("R4 logical shr", {16'h0, ac_q}, 32'h7FFF);
    step(3'd0, 3'd0, 3'd3, "R4 shift left");
    chk("R4 shl fills 0", {16'h0, ac_q}, 32'hFFFE);
    step(3'd0, 3'd0, 3'd5, "R4 pc inc");
    step(3'd0, 3'd5, 3'd0, "R3 dr from ac");
    step(3'd0, 3'd6, 3'd0, "R3 dr inc");
    chk("R3 dr inc", {16'h0, dr_q}, 32'hFFFF);
    step(3'd0, 3'd7, 3'd0, "R3 dr low from pc");
    chk("R3 dr keeps upper", {16'h0, dr_q}, 32'hF801);
    step(3'd5, 3'd0, 3'd0, "R5 ar from dr");
    chk("R5 ar low dr", {21'h0, ar_q}, 32'h001);
    step(3'd0, 3'd0, 3'd5, "R4 pc inc");
    step(3'd6, 3'd0, 3'd0, "R5 ar from pc");
    chk("R5 ar from pc", {21'h0, ar_q}, 32'h002);
    step(3'd7, 3'd0, 3'd0, "R8 write");
    step(3'd0, 3'd5, 3'd0, "R3 dr from ac");
    step(3'd0, 3'd4, 3'd0, "R8 read back");
    chk("R8 read returns written", {16'h0, dr_q}, 32'hF801);
    step(3'd4, 3'd5, 3'd0, "R7 swap");
    chk("R7 swap ac", {16'h0, ac_q}, 32'hF801);
    chk("R7 swap dr", {16'h0, dr_q}, 32'hFFFE);
    step(3'd4, 3'd0, 3'd0, "R2 ac from dr");
    step(3'd0, 3'd2, 3'd2, "R6 or beats invert");
    chk("R6 field two over three", {16'h0, ac_q}, 32'hFFFE);
    step(3'd0, 3'd0, 3'd7, "R4 reserved");
    chk("R4 reserved no change", {ac_q, dr_q}, {16'hFFFE, 16'hFFFE});
    step(3'd0, 3'd3, 3'd1, "R10 sub wrap prep");
    step(3'd2, 3'd0, 3'd0, "R2 clear");
    step(3'd0, 3'd1, 3'd0, "R10 subtract wrap");
    chk("R10 0 minus dr wraps", {16'h0, ac_q}, 32'h0002);

    for (int pass = 0; pass < 4; pass++) begin
      for (int k = 0; k < 512; k++) begin
        int code;
        code = (k * (197 + 64 * pass) + 37 * pass) % 512;
        step(code[8:6], code[5:3], code[2:0], "R2 R3 R4 R6 sweep");
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule